// File: doc/BRIEF.md
# Integer ALU with Grouped Opcodes

This block is the integer arithmetic-logic unit of a small load/store processor core. It takes two operand words and a 4-bit operation code. From these it produces a result word and a flag that marks an all-zero result. It has no clock and no state: the outputs follow the inputs through combinational logic alone.

The opcode is split into two fields. The upper two bits choose a class: arithmetic, logic or shift. The lower two bits choose the variant within that class, such as subtraction, a right shift, or the signed or arithmetic form. Subtraction and the signed compare share one adder. Every code that the map does not list yields a zero result, so a bad decode upstream leaves a defined value rather than garbage. The datapath width is a parameter, and the width of the shift-amount field follows from it.

Top module: `int_alu`

## Requirements
- R1: The opcode map is fixed. 0000 adds, 0001 subtracts (a minus b), 0011 is the signed less-than compare, 0100 is bitwise AND, 0101 is bitwise OR, 0110 is bitwise XOR, 1000 shifts left logically, 1001 shifts right logically and 1011 shifts right arithmetically.
- R2: Addition and subtraction wrap modulo 2^N. For N=32, 0xFFFFFFFF+0xFFFFFFFF gives 0xFFFFFFFE, 0xFFFFFFFF+1 gives 0, and 5-7 gives 0xFFFFFFFE.
- R3: The compare treats both operands as two's-complement values. It returns 1 in bit 0 when a is less than b, and 0 otherwise. All higher bits are 0, and the answer is correct even when a minus b overflows.
- R4: Every shift takes its amount from the low log2(N) bits of operand b only. For N=32 the amount is b modulo 32, so b=36 shifts by 4.
- R5: The logical right shift fills the vacated upper bits with zeros. The arithmetic right shift fills them with copies of bit N-1 of a.
- R6: The zero flag is 1 exactly when every bit of the result is 0. This holds for every opcode.
- R7: The codes 0010, 0111, 1010, 1100, 1101, 1110 and 1111 give an all-zero result, so the zero flag is 1.
- R8: AND, OR and XOR act on each bit position independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | N | First operand; the value shifted by shift operations |
| src_b | input | N | Second operand; its low log2(N) bits give the shift amount |
| op_sel | input | 4 | Operation code: class in bits 3:2, variant in bits 1:0 |
| alu_out | output | N | Result word |
| out_zero | output | 1 | High when alu_out is all zeros |

## Verification
The immediate assertions in the design are evaluated whenever the inputs change. They check the following:
- the compare clears every bit above bit 0;
- the arithmetic right shift of a negative operand keeps the top bit set;
- a non-zero logical right shift clears the top bit;
- a non-zero left shift clears bit 0;
- AND never sets a bit that is clear in a;
- unlisted codes give a zero word with the flag set.

Only the bench scenarios can show the rest. These cover the exact sums and differences with wraparound, signed compares across the overflow boundary, truncation of the shift amount, and exact bitwise values. Long pseudo-random runs per opcode are checked against a reference computed from the requirements.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int N = 32
) (
  input  logic [N-1:0] src_a,
  input  logic [N-1:0] src_b,
  input  logic [3:0]   op_sel,
  output logic [N-1:0] alu_out,
  output logic         out_zero
);
  localparam int SHW = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] CL_ARITH = 2'b00;
  localparam logic [1:0] CL_LOGIC = 2'b01;
  localparam logic [1:0] CL_SHIFT = 2'b10;

  logic [1:0]     op_class, op_var;
  logic           sub_en, ovf, lt;
  logic [N-1:0]   b_eff, sum;
  logic [SHW-1:0] sh;
  logic [N-1:0]   arith_r, logic_r, shift_r;

  assign op_class = op_sel[3:2];
  assign op_var   = op_sel[1:0];

  // one adder serves add, subtract and the signed compare
  assign sub_en = op_var[0];
  assign b_eff  = src_b ^ {N{sub_en}};
  assign sum    = src_a + b_eff + {{(N-1){1'b0}}, sub_en};
  assign ovf    = (src_a[N-1] == b_eff[N-1]) && (sum[N-1] != src_a[N-1]);
  assign lt     = sum[N-1] ^ ovf;

  always_comb begin
    case (op_var)
      2'b00, 2'b01: arith_r = sum;
      2'b11:        arith_r = {{(N-1){1'b0}}, lt};
      default:      arith_r = '0;
    endcase
  end

  always_comb begin
    case (op_var)
      2'b00:   logic_r = src_a & src_b;
      2'b01:   logic_r = src_a | src_b;
      2'b10:   logic_r = src_a ^ src_b;
      default: logic_r = '0;
    endcase
  end

  assign sh = src_b[SHW-1:0];

  always_comb begin
    case (op_var)
      2'b00:   shift_r = src_a << sh;
      2'b01:   shift_r = src_a >> sh;
      2'b11:   shift_r = $unsigned($signed(src_a) >>> sh);
      default: shift_r = '0;
    endcase
  end

  always_comb begin
    case (op_class)
      CL_ARITH: alu_out = arith_r;
      CL_LOGIC: alu_out = logic_r;
      CL_SHIFT: alu_out = shift_r;
      default:  alu_out = '0;
    endcase
  end

  assign out_zero = ~|alu_out;

  always_comb begin
    if (op_sel == 4'b0011)
      AST_CMP_UPPER_CLEAR: assert (alu_out[N-1:1] == '0); // R3
    if (op_sel == 4'b1011 && src_a[N-1])
      AST_ASR_SIGN_KEPT: assert (alu_out[N-1]); // R5
    if (op_sel == 4'b1001 && src_b[SHW-1:0] != '0)
      AST_LSR_TOP_CLEAR: assert (!alu_out[N-1]); // R5
    if (op_sel == 4'b1000 && src_b[SHW-1:0] != '0)
      AST_LSL_LOW_CLEAR: assert (!alu_out[0]); // R4
    if (op_sel == 4'b0100)
      AST_AND_WITHIN_A: assert ((alu_out & ~src_a) == '0); // R8
    if (op_sel == 4'b0010 || op_sel == 4'b0111 || op_sel == 4'b1010 || op_sel[3:2] == 2'b11)
      AST_BAD_CODE_ZERO: assert (alu_out == '0 && out_zero); // R7
  end
endmodule

// File: tb/test_int_alu.sv
`timescale 1ns/1ps
module test_int_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic [W-1:0] y;
  logic         z;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;

  int_alu #(.N(W)) i_int_alu (
    .src_a(a), .src_b(b), .op_sel(op), .alu_out(y), .out_zero(z)
  );

  function automatic logic [W-1:0] ref_alu(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] v);
    int s;
    s = int'(v % W);
    case (o)
      4'b0000: return x + v;
      4'b0001: return x - v;
      4'b0011: return ($signed(x) < $signed(v)) ? W'(1) : W'(0);
      4'b0100: return x & v;
      4'b0101: return x | v;
      4'b0110: return x ^ v;
      4'b1000: return x << s;
      4'b1001: return x >> s;
      4'b1011: return $unsigned($signed(x) >>> s);
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic apply(input string tag, input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] v, input logic [W-1:0] exp);
    op = o; a = x; b = v;
    #5;
    n_chk++;
    if (y !== exp || z !== (exp == '0)) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h: got %h/%b expected %h/%b",
               tag, o, x, v, y, z, exp, (exp == '0));
    end
  endtask

  task automatic t_add_sub;
    apply("R2", 4'b0000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE);
    apply("R2 R6", 4'b0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000);
    apply("R1 R6", 4'b0000, 32'h0, 32'h0, 32'h0);
    apply("R2", 4'b0001, 32'h5, 32'h7, 32'hFFFFFFFE);
    apply("R1 R6", 4'b0001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
  endtask

  task automatic t_compare;
    apply("R3", 4'b0011, 32'h8FFFFFFF, 32'hFFFFFFFF, 32'h1);
    apply("R3", 4'b0011, 32'hFFFFFFFF, 32'h00000001, 32'h1);
    apply("R3", 4'b0011, 32'h00000001, 32'hFFFFFFFF, 32'h0);
    apply("R3 ovf", 4'b0011, 32'h80000000, 32'h7FFFFFFF, 32'h1);
    apply("R3 ovf", 4'b0011, 32'h7FFFFFFF, 32'h80000000, 32'h0);
    apply("R3 equal", 4'b0011, 32'h12345678, 32'h12345678, 32'h0);
  endtask

  task automatic t_bitwise;
    apply("R8", 4'b0100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000);
    apply("R8", 4'b0101, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0);
    apply("R8 R6", 4'b0101, 32'h0, 32'h0, 32'h0);
    apply("R8 R6", 4'b0110, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
    apply("R8", 4'b0110, 32'h12345678, 32'hFFFFFFFF, 32'hEDCBA987);
  endtask

  task automatic t_shifts;
    apply("R1", 4'b1000, 32'h0000000F, 32'h4, 32'h000000F0);
    apply("R1", 4'b1000, 32'hFFFFFFFF, 32'h1C, 32'hF0000000);
    apply("R1", 4'b1000, 32'h01234567, 32'h1, 32'h02468ACE);
    apply("R4", 4'b1000, 32'h0000000F, 32'h24, 32'h000000F0);
    apply("R5", 4'b1001, 32'hF0000000, 32'h1C, 32'h0000000F);
    apply("R4 R5", 4'b1001, 32'h80000000, 32'h21, 32'h40000000);
    apply("R5", 4'b1011, 32'hF0000000, 32'h1C, 32'hFFFFFFFF);
    apply("R5 R6", 4'b1011, 32'h0000000F, 32'h4, 32'h0);
    apply("R4 R5", 4'b1011, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF);
  endtask

  task automatic t_bad_codes;
    apply("R7", 4'b0010, 32'hFFFFFFFF, 32'h1, 32'h0);
    apply("R7", 4'b0111, 32'hFFFFFFFF, 32'h1, 32'h0);
    apply("R7", 4'b1010, 32'hFFFFFFFF, 32'h1, 32'h0);
    apply("R7", 4'b1100, 32'hFFFFFFFF, 32'h1, 32'h0);
    apply("R7", 4'b1101, 32'h12345678, 32'h3, 32'h0);
    apply("R7", 4'b1110, 32'h80000000, 32'h7, 32'h0);
    apply("R7", 4'b1111, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
  endtask

  task automatic t_sweep;
    logic [3:0] codes [9] = '{4'b0000, 4'b0001, 4'b0011, 4'b0100, 4'b0101,
                             4'b0110, 4'b1000, 4'b1001, 4'b1011};
    logic [W-1:0] x, v;
    for (int c = 0; c < 9; c++) begin
      for (int k = 0; k < 200; k++) begin
        lfsr = step(lfsr); x = lfsr;
        lfsr = step(lfsr); v = lfsr;
        apply("R1 R6 sweep", codes[c], x, v, ref_alu(codes[c], x, v));
      end
    end
  endtask

  initial begin
    op = 4'b0000; a = '0; b = '0;
    #5;
    n_chk++;
    if (y !== 32'h0 || z !== 1'b1) begin
      n_bad++;
      $display("FAIL R6 idle: got %h/%b expected 00000000/1", y, z);
    end
    t_add_sub();
    t_compare();
    t_bitwise();
    t_shifts();
    t_bad_codes();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule